// File: doc/BRIEF.md
# Replayable FIFO with Rewind Input

This block is a single-clock first-in first-out buffer whose reads do not discard data. Every word written since the last reset stays in storage. Storage is filled from physical location zero upward, and the write side never wraps. A read only moves a read pointer forward. Driving the active-low rewind input low returns that pointer to location zero, so a receiver that rejects a packet can have the sender replay everything from the first word onward.

Words written after a rewind are delivered in order after the replayed ones. The whole storage can be replayed as many times as needed. The flags follow the pointers:

- empty means the read pointer has caught up with the write pointer;
- full means the storage has been written to its last location.

While the rewind input is low, and for a fixed number of clock edges after it returns high, the read and write enables are ignored. This gives the pointers and flags a clean recovery interval.

Top module: `rtx_fifo`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears itself. In the cycle after that edge, empty is 1, full is 0 and rd_data is all zeros.
- R2: A write is taken at an edge where wr_en is 1, full is 0 and the block is not locked. The word goes to the next unused location, counting up from location zero.
- R3: full becomes 1 once DEPTH words have been written since reset. While full is 1, writes are ignored and no stored word is overwritten, so a later replay still returns the original words.
- R4: A read is taken at an edge where rd_en is 1, empty is 0 and the block is not locked. After that edge, rd_data holds the word at the read pointer and the pointer advances by one. When no read is taken, rd_data keeps its value.
- R5: empty is 1 exactly when the read pointer equals the write pointer. Reads do not clear full.
- R6: rtx_n sampled low at an edge sets the read pointer to zero. In the following cycle, empty is recomputed: it is 0 if any word has been written since reset.
- R7: Both enables are ignored at every edge where rtx_n is low. They are also ignored at the RECOVER edges that follow the last such edge, and they take effect again at the edge after that.
- R8: After a rewind, reads return the words from location zero onward in the order they were written. Words written after the rewind follow them, and reading stops when the read pointer reaches the write pointer.
- R9: A full storage of DEPTH words can be rewound and replayed any number of times with identical results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Registered word from the last accepted read |
| rtx_n | input | 1 | Rewind request, active low, sampled at the clock edge |
| empty | output | 1 | Read pointer equals write pointer |
| full | output | 1 | DEPTH words written since reset |

## Verification
The assertions take for granted the following about the inputs:
- rtx_n is synchronous to clk.
- Enables and rewind carry known values from the first edge after reset onward.

The pointer properties rely on a rewind being the only event that moves the read pointer backward. The stimulus changes every input on the falling edge, and every pulse on rtx_n lasts whole cycles. Random enable and rewind patterns are allowed to fall inside the lockout window, because the design must ignore them there rather than being shielded from them.

// File: rtl/rtx_pkg.sv
// Package: shared types for the replayable FIFO.
// Assumes: nothing beyond a single clock domain.
package rtx_pkg;

    // Lockout sequencer states: idle, rewind held low, recovery countdown.
    typedef enum logic [1:0] {
        LK_IDLE    = 2'd0,
        LK_HOLD    = 2'd1,
        LK_RECOVER = 2'd2
    } lk_state_t;

endpackage

// File: rtl/rtx_lockout.sv
// Module: rtx_lockout
// Produces the rewind strobe and the enable lockout.
// lock is high at every edge where rtx_n is low, and at the RECOVER edges
// after the last low edge.
// Assumes: rtx_n is synchronous to clk and RECOVER >= 1.
module rtx_lockout
    import rtx_pkg::*;
#(
    parameter int RECOVER = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rtx_n,
    output logic rewind,
    output logic lock
);
    localparam int CW = (RECOVER < 2) ? 1 : $clog2(RECOVER + 1);

    lk_state_t     state;
    logic [CW-1:0] cnt;

    // Rewind strobe: follows the sampled input directly.
    assign rewind = !rtx_n;

    // Lockout: active while low, or while the sequencer is busy.
    assign lock = !rtx_n || (state != LK_IDLE);

    // Sequencer: tracks the low pulse, then counts down the recovery window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LK_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                LK_IDLE: begin
                    if (!rtx_n) state <= LK_HOLD;
                end
                LK_HOLD: begin
                    if (rtx_n) begin
                        if (RECOVER <= 1) begin
                            state <= LK_IDLE;
                        end else begin
                            state <= LK_RECOVER;
                            cnt   <= CW'(RECOVER - 1);
                        end
                    end
                end
                LK_RECOVER: begin
                    if (!rtx_n) begin
                        state <= LK_HOLD;
                    end else begin
                        cnt <= cnt - CW'(1);
                        if (cnt == CW'(1)) state <= LK_IDLE;
                    end
                end
                default: state <= LK_IDLE;
            endcase
        end
    end

    // A low sample always leaves the sequencer busy at the next edge (R7).
    assert_lock_after_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rtx_n |=> (state != LK_IDLE));

    // The countdown never sits at zero while recovering (R7).
    assert_recover_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_RECOVER) |-> (cnt != '0));

endmodule

// File: rtl/rtx_wr_ctrl.sv
// Module: rtx_wr_ctrl
// Write pointer and full flag.
// The pointer counts up from zero and stops at DEPTH; it never wraps, so
// each location holds the word written there since reset.
// Assumes: lock comes from rtx_lockout.
module rtx_wr_ctrl #(
    parameter int DEPTH = 16,
    parameter int PW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          lock,
    output logic          wr_go,
    output logic [PW-1:0] wptr,
    output logic          full
);
    // Full: storage written to its last location.
    assign full  = (wptr == PW'(DEPTH));

    // Accept: request, room left, not locked out.
    assign wr_go = wr_en && !full && !lock;

    // Pointer: advance on every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)     wptr <= '0;
        else if (wr_go) wptr <= wptr + PW'(1);
    end

    // No write moves the pointer once full (R3).
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> $stable(wptr));

    // Pointer never passes the physical end (R3).
    assert_wptr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wptr <= PW'(DEPTH));

    // Locked edges leave the write side untouched (R7).
    assert_lock_blocks_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(wptr));

endmodule

// File: rtl/rtx_rd_ctrl.sv
// Module: rtx_rd_ctrl
// Read pointer and empty flag.
// A rewind returns the pointer to zero; reads advance it up to the write
// pointer.
// Assumes: rewind implies lock, so a rewind and a read never share an edge.
module rtx_rd_ctrl #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          lock,
    input  logic          rewind,
    input  logic [PW-1:0] wptr,
    output logic          rd_go,
    output logic [PW-1:0] rptr,
    output logic          empty
);
    // Empty: read side has caught up with the write side.
    assign empty = (rptr == wptr);

    // Accept: request, data available, not locked out.
    assign rd_go = rd_en && !empty && !lock;

    // Pointer: rewind to zero, else advance on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)      rptr <= '0;
        else if (rewind) rptr <= '0;
        else if (rd_go)  rptr <= rptr + PW'(1);
    end

    // A rewind lands on the first physical location (R6).
    assert_rewind_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (rptr == '0));

    // The read side never overtakes the write side (R5).
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rptr <= wptr);

    // An empty FIFO holds its read pointer unless rewound (R4).
    assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !rewind) |=> $stable(rptr));

endmodule

// File: rtl/rtx_mem.sv
// Module: rtx_mem
// Word storage with a registered read port.
// The storage array is not reset; only the output register is.
// Assumes: the read and write addresses differ whenever both are active.
module rtx_mem #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    // Storage: write the accepted word.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Output register: load on an accepted read, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= store[raddr];
    end

    // Output changes only through an accepted read (R4).
    assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata));

endmodule

// File: rtl/rtx_fifo.sv
// Module: rtx_fifo (top)
// Replayable FIFO. Reads do not discard data; rtx_n low rewinds the read
// pointer to location zero. Enables are locked out during the pulse and
// for RECOVER edges after it.
// Assumes: single clock, synchronous active-low reset, RECOVER >= 1.
module rtx_fifo #(
    parameter int DW      = 16,
    parameter int DEPTH   = 16,
    parameter int RECOVER = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          rtx_n,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam int PW = $clog2(DEPTH + 1);

    logic          rewind;
    logic          lock;
    logic          wr_go;
    logic          rd_go;
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;

    rtx_lockout #(.RECOVER(RECOVER)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .rtx_n  (rtx_n),
        .rewind (rewind),
        .lock   (lock)
    );

    rtx_wr_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_wr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .lock  (lock),
        .wr_go (wr_go),
        .wptr  (wptr),
        .full  (full)
    );

    rtx_rd_ctrl #(.PW(PW)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .lock   (lock),
        .rewind (rewind),
        .wptr   (wptr),
        .rd_go  (rd_go),
        .rptr   (rptr),
        .empty  (empty)
    );

    rtx_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_go),
        .waddr (wptr[AW-1:0]),
        .wdata (wr_data),
        .re    (rd_go),
        .raddr (rptr[AW-1:0]),
        .rdata (rd_data)
    );

    // The flags are never both set with an empty storage (R5).
    assert_flags_consistent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && empty) |-> (rptr == PW'(DEPTH)));

    // A rewind with stored data clears empty next cycle (R6).
    assert_rewind_unempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rtx_n && wptr != '0) |=> !empty);

endmodule

// File: tb/tb_rtx_fifo.sv
// Bench: random and directed stimulus against a behavioural model.
module tb_rtx_fifo;
    localparam int DW      = 16;
    localparam int DEPTH   = 16;
    localparam int RECOVER = 3;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          rtx_n = 1'b1;
    logic [DW-1:0] rd_data;
    logic          empty;
    logic          full;

    int checks = 0;
    int fails  = 0;

    // Model state
    logic [DW-1:0] mmem [DEPTH];
    logic [DW-1:0] mdata;
    int mw, mr, mrec;

    rtx_fifo #(.DW(DW), .DEPTH(DEPTH), .RECOVER(RECOVER)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rtx_n(rtx_n),
        .empty(empty), .full(full)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        chk(empty == (mr == mw), tag, "empty", int'(empty), int'(mr == mw));
        chk(full == (mw == DEPTH), tag, "full", int'(full), int'(mw == DEPTH));
        chk(rd_data == mdata, tag, "rd_data", int'(rd_data), int'(mdata));
    endtask

    // One cycle: drive at the falling edge, update the model after the
    // rising edge, check at the next falling edge.
    task automatic step(input logic we, input logic [DW-1:0] wd,
                        input logic re, input logic rt, input string tag);
        bit lk, wok, rok;
        wr_en = we; wr_data = wd; rd_en = re; rtx_n = rt;
        lk  = !rt || (mrec > 0);
        wok = we && (mw < DEPTH) && !lk;
        rok = re && (mr < mw) && !lk;
        @(posedge clk); #1;
        if (rok) begin mdata = mmem[mr]; mr++; end
        if (wok) begin mmem[mw] = wd; mw++; end
        if (!rt) begin mr = 0; mrec = RECOVER; end
        else if (mrec > 0) mrec--;
        @(negedge clk);
        check_outs(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 0; rd_en = 0; rtx_n = 1;
        @(posedge clk); @(posedge clk); #1;
        mw = 0; mr = 0; mrec = 0; mdata = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rewind_and_recover(input string tag);
        step(1, DW'($urandom), 1, 0, tag);
        for (int i = 0; i < RECOVER; i++) step(1, DW'($urandom), 1, 1, "R7");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();
        check_outs("R1");
        chk(empty == 1'b1 && full == 1'b0, "R1", "reset flags", {empty, full}, 2);

        // R2 R4 R5: random writes and reads, no rewind.
        for (int i = 0; i < 60; i++)
            step(1'($urandom), DW'($urandom), 1'($urandom), 1, "R2");

        // R3: fill past the end; extra writes must be ignored.
        do_reset();
        for (int i = 0; i < DEPTH + 3; i++) step(1, DW'($urandom), 0, 1, "R3");
        chk(full == 1'b1, "R3", "full after fill", int'(full), 1);

        // R5: reads do not clear full.
        for (int i = 0; i < 5; i++) step(0, '0, 1, 1, "R5");
        chk(full == 1'b1, "R5", "full held after reads", int'(full), 1);

        // R6 R7: two-edge low pulse with enables held high.
        step(1, DW'($urandom), 1, 0, "R6");
        step(1, DW'($urandom), 1, 0, "R6");
        chk(empty == 1'b0, "R6", "empty after rewind", int'(empty), 0);
        for (int i = 0; i < RECOVER; i++) step(1, DW'($urandom), 1, 1, "R7");

        // R8: replay of the whole storage, then an ignored read on empty.
        for (int i = 0; i < DEPTH; i++) step(0, '0, 1, 1, "R8");
        step(0, '0, 1, 1, "R4");
        chk(empty == 1'b1, "R8", "empty after replay", int'(empty), 1);

        // R9: repeated full-depth replays.
        for (int k = 0; k < 2; k++) begin
            rewind_and_recover("R9");
            for (int i = 0; i < DEPTH; i++) step(0, '0, 1, 1, "R9");
        end

        // R8: words written after a rewind follow the replayed ones.
        do_reset();
        for (int i = 0; i < 5; i++) step(1, DW'($urandom), 0, 1, "R2");
        for (int i = 0; i < 3; i++) step(0, '0, 1, 1, "R4");
        rewind_and_recover("R6");
        for (int i = 0; i < 4; i++) step(1, DW'($urandom), 0, 1, "R8");
        for (int i = 0; i < 10; i++) step(0, '0, 1, 1, "R8");

        // R7: random traffic with rewinds landing anywhere.
        do_reset();
        for (int i = 0; i < 400; i++)
            step(1'($urandom), DW'($urandom), 1'($urandom),
                 ($urandom % 12) != 0, "R7");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule